// File: doc/BRIEF.md
# Serial EEPROM Target Emulator

This block sits behind the four pins of an SPI mode-0 bus and answers like a small byte-wide serial EEPROM. It runs entirely on the system clock. SCK, chip select and MOSI are brought in through synchronizer chains, and their edges are detected in the system-clock domain. A host can set and clear a write-enable latch, read or write a small status byte, stream data out of an internal byte array, and write up to one page of data per transaction.

Written data is first collected in a page staging buffer. It is committed to the array on the rising edge of chip select. The commit starts a busy interval, counted in system clocks, and the not-ready flag reports it. During that interval only status reads are honoured.

The address phase is one, two or three bytes long, chosen by a parameter. An optional mode takes address bit 8 from bit 3 of the read or write instruction, which lets a one-byte address reach a 512-byte array.

Top module: `spi_eeprom_target`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and MISO is low whenever chip select is high.
- R2: Instruction codes are 0x06 enable writes, 0x04 disable writes, 0x05 read status, 0x01 write status, 0x03 read and 0x02 write. In the status byte, bit 0 is not-ready, bit 1 is the write-enable latch, bits 3:2 are the protect bits and bit 7 is the protect-enable bit. Bits 6:4 read as zero.
- R3: Instruction 0x06 sets status bit 1 and instruction 0x04 clears it, each at the end of its instruction byte.
- R4: A write or status-write instruction issued while status bit 1 is clear has no effect. A committed write clears status bit 1.
- R5: A write that carried at least one data byte is committed when chip select rises. Status bit 0 then reads 1 for exactly BUSY_CYCLES system clocks.
- R6: While status bit 0 is set, every instruction except 0x05 is ignored, and MISO returns 0x00 for its data bytes.
- R7: Write data fills successive addresses. After the last byte of a PAGE_BYTES-aligned page it wraps to the first byte of the same page, and a later byte overwrites an earlier one at the same address.
- R8: A read streams bytes from the start address for as long as chip select stays low. After the last array byte it continues at address 0.
- R9: With NINTH_BIT set and a one-byte address, bit 3 of the read or write instruction (0x0B, 0x0A) supplies address bit 8.
- R10: Instruction 0x05 returns the current status byte in every data byte while chip select stays low.
- R11: Instruction 0x01, issued with the write-enable latch set, loads bits 7, 3 and 2 from its first data byte when chip select rises. It clears the latch and starts the busy interval.
- R12: MOSI is sampled on SCK rising edges, and MISO changes only after SCK falling edges. Both carry the most significant bit first, and addresses are sent most significant byte first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, held low while deselected |

## Verification
A wrong internal state shows at MISO on the next status or data byte. A stuck or miscounted busy counter changes status bit 0 within one status byte. A write-enable latch that is not cleared, or a command accepted during busy, shows in the next status read. A staging buffer that misroutes a byte shows only when that address is read back. For that reason the bench writes every page of the array and then streams the whole array back, together with the wrap past the last address.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;

   // mask that removes the instruction bit used as address bit 8
   localparam logic [7:0] OP_A8_MASK = 8'hF7;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADDR,
      ST_RD,
      ST_WR,
      ST_SRD,
      ST_SWR,
      ST_SKIP
   } eep_state_t;

endpackage

// File: rtl/spi_eep_phy.sv
module spi_eep_phy #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   input  logic [7:0] tx_byte,
   output logic       cs_act,
   output logic       cs_rise,
   output logic       sck_fall,
   output logic       rx_valid,
   output logic [7:0] rx_byte,
   output logic       miso
);

   logic [SYNC_STAGES:0]   sck_ln;
   logic [SYNC_STAGES:0]   csn_ln;
   logic [SYNC_STAGES-1:0] mosi_ln;
   logic                   sck_rise;
   logic                   mosi_q;
   logic [2:0]             bit_cnt;
   logic [6:0]             rx_sh;
   logic [7:0]             tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_ln  <= '0;
         csn_ln  <= '1;
         mosi_ln <= '0;
      end else begin
         sck_ln  <= {sck_ln[SYNC_STAGES-1:0], spi_sck};
         csn_ln  <= {csn_ln[SYNC_STAGES-1:0], spi_cs_n};
         mosi_ln <= {mosi_ln[SYNC_STAGES-2:0], spi_mosi};
      end
   end

   assign sck_rise = sck_ln[SYNC_STAGES-1] & ~sck_ln[SYNC_STAGES];
   assign sck_fall = ~sck_ln[SYNC_STAGES-1] & sck_ln[SYNC_STAGES];
   assign cs_act   = ~csn_ln[SYNC_STAGES-1];
   assign cs_rise  = csn_ln[SYNC_STAGES-1] & ~csn_ln[SYNC_STAGES];
   assign mosi_q   = mosi_ln[SYNC_STAGES-1];

   assign rx_valid = cs_act & sck_rise & (bit_cnt == 3'd7);
   assign rx_byte  = {rx_sh, mosi_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso    <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso    <= 1'b0;
      end else begin
         if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= {rx_sh[5:0], mosi_q};
         end
         if (sck_fall) begin
            if (bit_cnt == 3'd0) begin
               miso  <= tx_byte[7];
               tx_sh <= {tx_byte[6:0], 1'b0};
            end else begin
               miso  <= tx_sh[7];
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/spi_eep_store.sv
module spi_eep_store #(
   parameter int MEM_BYTES  = 512,
   parameter int PAGE_BYTES = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
   output logic [7:0]                   rd_data,
   input  logic                         stg_clr,
   input  logic                         stg_we,
   input  logic [$clog2(MEM_BYTES)-1:0] stg_addr,
   input  logic [7:0]                   stg_data,
   input  logic                         commit
);

   localparam int AW = $clog2(MEM_BYTES);
   localparam int PW = $clog2(PAGE_BYTES);

   logic [7:0]            mem  [MEM_BYTES];
   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] pmask;
   logic [AW-PW-1:0]      pg;

   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
         for (int j = 0; j < PAGE_BYTES; j++) pbuf[j] <= 8'h00;
         pmask <= '0;
         pg    <= '0;
      end else begin
         if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
               if (pmask[j]) mem[{pg, PW'(j)}] <= pbuf[j];
            end
         end
         if (stg_clr) pmask <= '0;
         if (stg_we) begin
            pg                      <= stg_addr[AW-1:PW];
            pbuf[stg_addr[PW-1:0]]  <= stg_data;
            pmask[stg_addr[PW-1:0]] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
   import spi_eep_pkg::*;
#(
   parameter int ADDR_BYTES  = 1,
   parameter int NINTH_BIT   = 1,
   parameter int MEM_BYTES   = 512,
   parameter int PAGE_BYTES  = 16,
   parameter int BUSY_CYCLES = 1000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cs_act,
   input  logic                         cs_rise,
   input  logic                         rx_valid,
   input  logic [7:0]                   rx_byte,
   input  logic [7:0]                   rd_data,
   output logic [7:0]                   tx_byte,
   output logic [$clog2(MEM_BYTES)-1:0] rd_addr,
   output logic                         stg_clr,
   output logic                         stg_we,
   output logic [$clog2(MEM_BYTES)-1:0] stg_addr,
   output logic [7:0]                   stg_data,
   output logic                         commit,
   output logic                         busy,
   output logic                         wel
);

   localparam int AW  = $clog2(MEM_BYTES);
   localparam int PW  = $clog2(PAGE_BYTES);
   localparam int BCW = $clog2(BUSY_CYCLES + 1);

   eep_state_t     st;
   logic [1:0]     acnt;
   logic           is_wr;
   logic [AW-1:0]  ashift;
   logic [AW-1:0]  cur;
   logic [AW-1:0]  addr_full;
   logic [BCW-1:0] bcnt;
   logic           wr_have;
   logic           sr_have;
   logic [1:0]     bp_new;
   logic           wpen_new;
   logic [1:0]     bp;
   logic           wpen;
   logic [7:0]     status;
   logic [7:0]     op_cmd;
   logic           op_a8;

   // instruction decode variant: bit 3 of read/write may carry address bit 8
   if (NINTH_BIT != 0) begin : g_ninth
      always_comb begin
         op_cmd = rx_byte;
         op_a8  = 1'b0;
         if ((rx_byte & OP_A8_MASK) == OP_READ || (rx_byte & OP_A8_MASK) == OP_WRITE) begin
            op_cmd = rx_byte & OP_A8_MASK;
            op_a8  = rx_byte[3];
         end
      end
   end else begin : g_plain
      assign op_cmd = rx_byte;
      assign op_a8  = 1'b0;
   end

   assign busy      = (bcnt != '0);
   assign status    = {wpen, 3'b000, bp, wel, busy};
   assign addr_full = AW'({ashift, rx_byte});
   assign rd_addr   = (st == ST_ADDR) ? addr_full : cur;
   assign stg_we    = rx_valid & (st == ST_WR);
   assign stg_addr  = cur;
   assign stg_data  = rx_byte;
   assign stg_clr   = cs_rise;
   assign commit    = cs_rise & wr_have;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OPC;
         acnt     <= '0;
         is_wr    <= 1'b0;
         ashift   <= '0;
         cur      <= '0;
         bcnt     <= '0;
         wr_have  <= 1'b0;
         sr_have  <= 1'b0;
         bp_new   <= '0;
         wpen_new <= 1'b0;
         bp       <= '0;
         wpen     <= 1'b0;
         wel      <= 1'b0;
         tx_byte  <= '0;
      end else begin
         if (busy) bcnt <= bcnt - BCW'(1);
         if (cs_rise) begin
            if (wr_have || sr_have) begin
               wel  <= 1'b0;
               bcnt <= BCW'(BUSY_CYCLES);
            end
            if (sr_have) begin
               bp   <= bp_new;
               wpen <= wpen_new;
            end
            wr_have <= 1'b0;
            sr_have <= 1'b0;
         end
         if (!cs_act) begin
            st      <= ST_OPC;
            tx_byte <= '0;
         end else if (rx_valid) begin
            tx_byte <= '0;
            case (st)
               ST_OPC: begin
                  st <= ST_SKIP;
                  if (busy) begin
                     if (op_cmd == OP_RDSR) begin
                        st      <= ST_SRD;
                        tx_byte <= status;
                     end
                  end else begin
                     case (op_cmd)
                        OP_WREN: wel <= 1'b1;
                        OP_WRDI: wel <= 1'b0;
                        OP_RDSR: begin
                           st      <= ST_SRD;
                           tx_byte <= status;
                        end
                        OP_WRSR: if (wel) st <= ST_SWR;
                        OP_READ: begin
                           st     <= ST_ADDR;
                           is_wr  <= 1'b0;
                           acnt   <= 2'(ADDR_BYTES - 1);
                           ashift <= AW'(op_a8);
                        end
                        OP_WRITE: if (wel) begin
                           st     <= ST_ADDR;
                           is_wr  <= 1'b1;
                           acnt   <= 2'(ADDR_BYTES - 1);
                           ashift <= AW'(op_a8);
                        end
                        default: ;
                     endcase
                  end
               end
               ST_ADDR: begin
                  ashift <= addr_full;
                  acnt   <= acnt - 2'd1;
                  if (acnt == 2'd0) begin
                     if (is_wr) begin
                        st  <= ST_WR;
                        cur <= addr_full;
                     end else begin
                        st      <= ST_RD;
                        tx_byte <= rd_data;
                        cur     <= addr_full + AW'(1);
                     end
                  end
               end
               ST_RD: begin
                  tx_byte <= rd_data;
                  cur     <= cur + AW'(1);
               end
               ST_WR: begin
                  wr_have <= 1'b1;
                  cur     <= {cur[AW-1:PW], cur[PW-1:0] + PW'(1)};
               end
               ST_SRD: tx_byte <= status;
               ST_SWR: begin
                  bp_new   <= rx_byte[3:2];
                  wpen_new <= rx_byte[7];
                  sr_have  <= 1'b1;
                  st       <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target #(
   parameter int ADDR_BYTES  = 1,
   parameter int NINTH_BIT   = 1,
   parameter int MEM_BYTES   = 512,
   parameter int PAGE_BYTES  = 16,
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int AW     = $clog2(MEM_BYTES);
   localparam int ABITS  = 8 * ADDR_BYTES + NINTH_BIT;

   if (ADDR_BYTES < 1 || ADDR_BYTES > 3) begin : g_chk_ab
      $error("ADDR_BYTES must be 1, 2 or 3");
   end
   if (NINTH_BIT != 0 && ADDR_BYTES != 1) begin : g_chk_nb
      $error("NINTH_BIT needs a one-byte address");
   end
   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || AW > ABITS) begin : g_chk_mem
      $error("MEM_BYTES must be a power of two reachable by the address");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 || PAGE_BYTES >= MEM_BYTES) begin : g_chk_pg
      $error("PAGE_BYTES must be a power of two, at least 2, below MEM_BYTES");
   end
   if (BUSY_CYCLES < 1 || SYNC_STAGES < 2) begin : g_chk_misc
      $error("BUSY_CYCLES must be positive and SYNC_STAGES at least 2");
   end

   logic          cs_act;
   logic          cs_rise;
   logic          sck_fall;
   logic          rx_valid;
   logic [7:0]    rx_byte;
   logic [7:0]    tx_byte;
   logic [7:0]    rd_data;
   logic [AW-1:0] rd_addr;
   logic          stg_clr;
   logic          stg_we;
   logic [AW-1:0] stg_addr;
   logic [7:0]    stg_data;
   logic          commit;
   logic          busy;
   logic          wel;

   spi_eep_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (spi_sck),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi),
      .tx_byte  (tx_byte),
      .cs_act   (cs_act),
      .cs_rise  (cs_rise),
      .sck_fall (sck_fall),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .miso     (spi_miso)
   );

   spi_eep_ctrl #(
      .ADDR_BYTES  (ADDR_BYTES),
      .NINTH_BIT   (NINTH_BIT),
      .MEM_BYTES   (MEM_BYTES),
      .PAGE_BYTES  (PAGE_BYTES),
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .cs_rise  (cs_rise),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .rd_data  (rd_data),
      .tx_byte  (tx_byte),
      .rd_addr  (rd_addr),
      .stg_clr  (stg_clr),
      .stg_we   (stg_we),
      .stg_addr (stg_addr),
      .stg_data (stg_data),
      .commit   (commit),
      .busy     (busy),
      .wel      (wel)
   );

   spi_eep_store #(
      .MEM_BYTES  (MEM_BYTES),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .stg_clr  (stg_clr),
      .stg_we   (stg_we),
      .stg_addr (stg_addr),
      .stg_data (stg_data),
      .commit   (commit)
   );

endmodule

// File: rtl/spi_eep_checker.sv
module spi_eep_checker #(
   parameter int BUSY_CYCLES = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic spi_cs_n,
   input logic spi_miso,
   input logic cs_act,
   input logic cs_rise,
   input logic sck_fall,
   input logic busy,
   input logic wel
);

   localparam int LW = $clog2(BUSY_CYCLES + 2);

   logic [LW-1:0] blen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    blen <= '0;
      else if (busy) blen <= blen + LW'(1);
      else           blen <= '0;
   end

   // R1
   idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(spi_cs_n, 3) && $past(spi_cs_n, 2) |-> !spi_miso);

   // R12
   miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_miso) |-> $past(sck_fall) || $past(!cs_act));

   // R5
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_rise));

   // R4
   wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);

   // R6
   busy_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(wel));

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> blen < LW'(BUSY_CYCLES));

   // R5
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> blen == LW'(BUSY_CYCLES));

endmodule

bind spi_eeprom_target spi_eep_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .spi_cs_n (spi_cs_n),
   .spi_miso (spi_miso),
   .cs_act   (cs_act),
   .cs_rise  (cs_rise),
   .sck_fall (sck_fall),
   .busy     (busy),
   .wel      (wel)
);

// File: tb/spi_eeprom_target_bench.sv
`timescale 1ns/1ps
module spi_eeprom_target_bench;

   localparam int MEMB = 512;
   localparam int PAGE = 16;
   localparam int BUSY = 800;
   localparam int HALF = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_mosi = 1'b0;
   logic spi_miso;

   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   logic [7:0] model [MEMB];
   logic [7:0] wbuf  [32];

   always #2.5 clk = ~clk;

   spi_eeprom_target #(
      .ADDR_BYTES  (1),
      .NINTH_BIT   (1),
      .MEM_BYTES   (MEMB),
      .PAGE_BYTES  (PAGE),
      .BUSY_CYCLES (BUSY),
      .SYNC_STAGES (2)
   ) u_spi_eeprom_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (spi_sck),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso)
   );

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
      for (int b = 7; b >= 0; b--) begin
         spi_mosi = o[b];
         repeat (HALF) @(negedge clk);
         i[b] = spi_miso;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic cs_lo();
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      cs_lo();
      xbyte(op, d);
      cs_hi();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      cs_lo();
      xbyte(8'h05, d);
      xbyte(8'h00, s);
      cs_hi();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] d;
      cs_lo();
      xbyte(8'h01, d);
      xbyte(v, d);
      cs_hi();
   endtask

   task automatic do_write(input logic [7:0] op, input logic [7:0] a, input int n,
                           input bit apply, input logic [8:0] base);
      logic [7:0] d;
      cs_lo();
      xbyte(op, d);
      xbyte(a, d);
      for (int k = 0; k < n; k++) begin
         xbyte(wbuf[k], d);
         if (apply) model[{base[8:4], 4'((int'(base[3:0]) + k) % PAGE)}] = wbuf[k];
      end
      cs_hi();
   endtask

   task automatic rd_chk(input logic [7:0] op, input logic [7:0] a, input int n,
                         input logic [8:0] base, input string req);
      logic [7:0] d;
      logic [7:0] g;
      cs_lo();
      xbyte(op, d);
      xbyte(a, d);
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, g);
         chk(g, model[(int'(base) + k) % MEMB], req);
      end
      cs_hi();
   endtask

   task automatic wait_ready();
      repeat (BUSY + 20) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      logic [7:0] s2;
      logic [7:0] d;
      logic [7:0] g;
      for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      chk({7'b0, spi_miso}, 8'h00, "R1 miso idle");
      rdsr(s);
      chk(s, 8'h00, "R1 status");
      rd_chk(8'h03, 8'h00, 4, 9'h000, "R1 erased");

      // R3: latch set and clear
      cmd1(8'h06);
      rdsr(s);
      chk(s, 8'h02, "R3 set");
      cmd1(8'h04);
      rdsr(s);
      chk(s, 8'h00, "R3 clear");

      // R4: write without latch is ignored
      wbuf[0] = 8'h55;
      do_write(8'h02, 8'h10, 1, 1'b0, 9'h010);
      rdsr(s);
      chk(s, 8'h00, "R4 no busy");
      rd_chk(8'h03, 8'h10, 1, 9'h010, "R4 no write");

      // R5/R10/R6: commit, busy window, ignored commands while busy
      cmd1(8'h06);
      wbuf[0] = 8'hA5;
      do_write(8'h02, 8'h20, 1, 1'b1, 9'h020);
      cs_lo();
      xbyte(8'h05, d);
      xbyte(8'h00, s);
      xbyte(8'h00, s2);
      cs_hi();
      chk(s, 8'h01, "R4 latch cleared, R5 busy");
      chk(s2, 8'h01, "R10 repeat");
      cmd1(8'h06);
      cs_lo();
      xbyte(8'h03, d);
      xbyte(8'h20, d);
      xbyte(8'h00, g);
      chk(g, 8'h00, "R6 read blocked");
      xbyte(8'h00, g);
      chk(g, 8'h00, "R6 read blocked");
      cs_hi();
      wait_ready();
      rdsr(s);
      chk(s, 8'h00, "R6 enable ignored, R5 ready");
      rd_chk(8'h03, 8'h20, 1, 9'h020, "R5 committed");

      // R11/R2: status register write
      cmd1(8'h06);
      wrsr(8'hFF);
      rdsr(s);
      chk(s, 8'h8D, "R11 busy after status write");
      wait_ready();
      rdsr(s);
      chk(s, 8'h8C, "R2 status layout");
      cmd1(8'h06);
      wrsr(8'h00);
      wait_ready();
      rdsr(s);
      chk(s, 8'h00, "R11 cleared");
      wrsr(8'h80);
      rdsr(s);
      chk(s, 8'h00, "R11 no latch ignored");

      // R7: page wrap
      cmd1(8'h06);
      for (int k = 0; k < 20; k++) wbuf[k] = 8'(8'hC0 + k);
      do_write(8'h02, 8'h3E, 20, 1'b1, 9'h03E);
      wait_ready();
      rd_chk(8'h03, 8'h30, 17, 9'h030, "R7 page wrap");

      // R9: instruction bit 3 is address bit 8
      cmd1(8'h06);
      wbuf[0] = 8'h3C;
      do_write(8'h0A, 8'h05, 1, 1'b1, 9'h105);
      wait_ready();
      rd_chk(8'h03, 8'h05, 1, 9'h005, "R9 low half");
      rd_chk(8'h0B, 8'h05, 1, 9'h105, "R9 high half");

      // R12/R8: fill every page, stream the whole array and past its end
      for (int p = 0; p < MEMB / PAGE; p++) begin
         cmd1(8'h06);
         for (int k = 0; k < PAGE; k++) wbuf[k] = 8'(((p * PAGE + k) * 37 + 11) % 256);
         do_write((p >= 16) ? 8'h0A : 8'h02, 8'((p * PAGE) % 256), PAGE, 1'b1, 9'(p * PAGE));
         wait_ready();
      end
      cs_lo();
      xbyte(8'h03, d);
      xbyte(8'h00, d);
      for (int k = 0; k < MEMB + 2; k++) begin
         xbyte(8'h00, g);
         chk(g, model[k % MEMB], (k >= MEMB) ? "R8 array wrap" : "R12 sweep");
      end
      cs_hi();

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule